// File: doc/BRIEF.md
# Receive Message Ring with Transmit-Truncated Depth

This block keeps track of the receive slots that a CAN-style controller uses as a circular queue of incoming messages. There are two fixed receive slots, followed by six general slots. Each general slot can be set to transmit or to receive. The queue always starts at fixed slot 0 and runs through consecutive slots. It ends just before the first general slot that is set to transmit, so its depth is anywhere from 2 to 8. Message data, bit timing and identifier filtering are handled elsewhere. This block holds only the occupancy state and the pointers.

Slots are numbered 0 to 7. Slots 0 and 1 are the fixed receive slots, and slot 2+k is general slot k. When the filter logic accepts a message, the block marks the slot at the internal write pointer as occupied and moves the write pointer on. Software reads the 4-bit read pointer to find the oldest unread slot. When it has finished with that slot, it releases the slot, and the read pointer moves forward. On each stored reception the block signals a fixed event code. It also raises an early-warning pulse when the free space reaches a selectable level. If a message arrives while the queue is full, the message is dropped and a sticky overflow indication is set.

Top module: `rxq_ring_ctrl`

## Requirements
- R1: The queue depth is 2 + k, where k is the index of the lowest-numbered general slot whose bit in `prog_is_tx_i` is 1. The depth is 8 when no bit is set. Slots at or above the depth are never marked occupied.
- R2: An accept with the slot at the write pointer free sets that slot's bit in `full_o` on the next edge. The write pointer then moves to the next slot, and it wraps from depth-1 to slot 0.
- R3: `rd_ptr_o` gives the slot number of the oldest unread slot. A release (`rd_clear_i`) while that slot is occupied clears its `full_o` bit. The read pointer then moves to the next slot, and it wraps from depth-1 to slot 0.
- R4: `empty_o` is 1 exactly when the `full_o` bit of the slot at `rd_ptr_o` is 0.
- R5: In the cycle after a stored reception, `irq_code_o` equals 5'b10000. In every other cycle it is 5'b00000.
- R6: `wm_irq_o` pulses for one cycle after a stored reception that leaves exactly 1 free slot (`wm_sel_i`=0) or exactly 4 free slots (`wm_sel_i`=1). The free count is the depth minus the occupancy after that cycle's accept and release.
- R7: An accept while the slot at the write pointer is occupied is dropped. The write pointer holds, no `full_o` bit changes, and `overflow_o` becomes 1 and stays 1.
- R8: A release while the queue is empty is ignored. The read pointer and `full_o` stay unchanged.
- R9: When `prog_is_tx_i` differs from its previously registered value, on the next edge both pointers go to 0 and all `full_o` bits, `overflow_o`, `irq_code_o` and `wm_irq_o` clear. An accept or release in that cycle is ignored.
- R10: After reset, `rd_ptr_o`, `full_o`, `irq_code_o`, `wm_irq_o` and `overflow_o` are 0, and `empty_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_accept_i | input | 1 | Filter accepted an incoming message this cycle |
| prog_is_tx_i | input | 6 | Per general slot: 1 = transmit, 0 = receive |
| rd_clear_i | input | 1 | Software releases the slot at the read pointer |
| wm_sel_i | input | 1 | Early-warning level: 0 = one free slot, 1 = four free slots |
| rd_ptr_o | output | 4 | Slot number of the oldest unread slot |
| full_o | output | 8 | Occupied flag per slot |
| empty_o | output | 1 | Queue holds no unread message |
| irq_code_o | output | 5 | Reception event code |
| wm_irq_o | output | 1 | Early-warning pulse |
| overflow_o | output | 1 | Sticky dropped-message flag |

## Verification
The bench fills and drains the queue under depths 2, 5, 7 and 8. In each case both pointers must wrap at the truncated depth. A design that wrapped at 8 would mark a transmit slot as occupied, or would point the reader at one. Accepts against a full queue must leave the write pointer in place and set the sticky flag. A design that advanced anyway would overwrite unread data. Releases against an empty queue must leave the read pointer alone. An accept and a release in the same cycle, taken at each fill level, checks that the early-warning pulse uses the net occupancy and both levels. Configuration changes made in the middle of traffic must flush all state, and an accept or release in that same cycle must be discarded.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam logic [4:0] RXQ_EVT_CODE = 5'b10000;
   localparam logic [4:0] RXQ_NO_CODE  = 5'b00000;
endpackage

// File: rtl/rxq_depth_calc.sv
module rxq_depth_calc #(
   parameter int NUM_DED  = 2,
   parameter int NUM_PROG = 6,
   parameter int CNT_W    = 4
) (
   input  logic [NUM_PROG-1:0] tx_mask_i,
   output logic [CNT_W-1:0]    depth_o
);
   always_comb begin
      depth_o = CNT_W'(NUM_DED + NUM_PROG);
      for (int k = NUM_PROG - 1; k >= 0; k--) begin
         if (tx_mask_i[k]) depth_o = CNT_W'(NUM_DED + k);
      end
   end
endmodule

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             adv_i,
   input  logic [PTR_W-1:0] last_i,
   output logic [PTR_W-1:0] ptr_o
);
   logic [PTR_W-1:0] nxt;

   assign nxt = (ptr_o == last_i) ? '0 : ptr_o + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_o <= '0;
      else if (flush_i) ptr_o <= '0;
      else if (adv_i)   ptr_o <= nxt;
   end
endmodule

// File: rtl/rxq_slot_flags.sv
module rxq_slot_flags #(
   parameter int NSLOT = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             set_i,
   input  logic [SEL_W-1:0] set_idx_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] clr_idx_i,
   output logic [NSLOT-1:0] full_o
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic hit_set, hit_clr;
      assign hit_set = set_i && (set_idx_i == SEL_W'(s));
      assign hit_clr = clr_i && (clr_idx_i == SEL_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       full_o[s] <= 1'b0;
         else if (flush_i) full_o[s] <= 1'b0;
         else if (hit_set) full_o[s] <= 1'b1;
         else if (hit_clr) full_o[s] <= 1'b0;
      end
      AST_NO_SET_CLR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
         !(hit_set && hit_clr)); // R2
   end
endmodule

// File: rtl/rxq_ring_ctrl.sv
module rxq_ring_ctrl #(
   parameter int NUM_DED  = 2,
   parameter int NUM_PROG = 6,
   parameter int PTR_W    = 4,
   parameter int CODE_W   = 5,
   parameter int WM_LO    = 1,
   parameter int WM_HI    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        msg_accept_i,
   input  logic [NUM_PROG-1:0]         prog_is_tx_i,
   input  logic                        rd_clear_i,
   input  logic                        wm_sel_i,
   output logic [PTR_W-1:0]            rd_ptr_o,
   output logic [NUM_DED+NUM_PROG-1:0] full_o,
   output logic                        empty_o,
   output logic [CODE_W-1:0]           irq_code_o,
   output logic                        wm_irq_o,
   output logic                        overflow_o
);
   import rxq_pkg::*;

   localparam int NSLOT = NUM_DED + NUM_PROG;
   localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
   localparam int CNT_W = $clog2(NSLOT + 1);

   if (NUM_DED < 1)     begin : g_bad_ded  $error("NUM_DED must be at least 1"); end
   if (PTR_W < SEL_W)   begin : g_bad_ptr  $error("PTR_W too narrow for slot count"); end
   if (CODE_W != 5)     begin : g_bad_code $error("CODE_W must be 5"); end
   if (WM_HI > NSLOT)   begin : g_bad_wm   $error("WM_HI exceeds slot count"); end

   logic [NUM_PROG-1:0] cfg_q;
   logic                cfg_chg;
   logic [CNT_W-1:0]    depth, cnt_q, cnt_nxt, thr;
   logic [PTR_W-1:0]    wr_ptr, last_idx;
   logic [NSLOT-1:0]    full_q, valid_mask;
   logic                wr_ok, clr_ok, drop;

   assign cfg_chg = (prog_is_tx_i != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= prog_is_tx_i;
   end

   rxq_depth_calc #(.NUM_DED(NUM_DED), .NUM_PROG(NUM_PROG), .CNT_W(CNT_W)) u_depth (
      .tx_mask_i(cfg_q), .depth_o(depth));

   assign last_idx = PTR_W'(depth - 1'b1);

   assign wr_ok  = msg_accept_i && !full_q[wr_ptr[SEL_W-1:0]] && !cfg_chg;
   assign drop   = msg_accept_i &&  full_q[wr_ptr[SEL_W-1:0]] && !cfg_chg;
   assign clr_ok = rd_clear_i   &&  full_q[rd_ptr_o[SEL_W-1:0]] && !cfg_chg;

   rxq_ptr #(.PTR_W(PTR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .flush_i(cfg_chg), .adv_i(wr_ok),
      .last_i(last_idx), .ptr_o(wr_ptr));

   rxq_ptr #(.PTR_W(PTR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .flush_i(cfg_chg), .adv_i(clr_ok),
      .last_i(last_idx), .ptr_o(rd_ptr_o));

   rxq_slot_flags #(.NSLOT(NSLOT), .SEL_W(SEL_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .flush_i(cfg_chg),
      .set_i(wr_ok), .set_idx_i(wr_ptr[SEL_W-1:0]),
      .clr_i(clr_ok), .clr_idx_i(rd_ptr_o[SEL_W-1:0]),
      .full_o(full_q));

   always_comb begin
      cnt_nxt = cnt_q;
      if (wr_ok && !clr_ok) cnt_nxt = cnt_q + 1'b1;
      if (!wr_ok && clr_ok) cnt_nxt = cnt_q - 1'b1;
   end

   assign thr = wm_sel_i ? CNT_W'(WM_HI) : CNT_W'(WM_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         irq_code_o <= RXQ_NO_CODE;
         wm_irq_o   <= 1'b0;
         overflow_o <= 1'b0;
      end else if (cfg_chg) begin
         cnt_q      <= '0;
         irq_code_o <= RXQ_NO_CODE;
         wm_irq_o   <= 1'b0;
         overflow_o <= 1'b0;
      end else begin
         cnt_q      <= cnt_nxt;
         irq_code_o <= wr_ok ? RXQ_EVT_CODE : RXQ_NO_CODE;
         wm_irq_o   <= wr_ok && ((depth - cnt_nxt) == thr);
         if (drop) overflow_o <= 1'b1;
      end
   end

   always_comb begin
      for (int s = 0; s < NSLOT; s++) valid_mask[s] = (CNT_W'(s) < depth);
   end

   assign full_o  = full_q;
   assign empty_o = !full_q[rd_ptr_o[SEL_W-1:0]];

   AST_TRUNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q & ~valid_mask) == '0); // R1
   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(rd_ptr_o) < depth) && (CNT_W'(wr_ptr) < depth)); // R3
   AST_WR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> wr_ptr != $past(wr_ptr)); // R2
   AST_RD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ok |=> rd_ptr_o != $past(rd_ptr_o)); // R3
   AST_EVT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> irq_code_o == RXQ_EVT_CODE); // R5
   AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ($stable(wr_ptr) && overflow_o)); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o && !cfg_chg) |=> overflow_o); // R7
   AST_EMPTY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear_i && empty_o && !msg_accept_i && !cfg_chg) |=> ($stable(rd_ptr_o) && $stable(full_q))); // R8
   AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> (full_q == '0 && rd_ptr_o == '0 && wr_ptr == '0 && !overflow_o)); // R9
   AST_WM_ONLY_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
      wm_irq_o |-> irq_code_o == RXQ_EVT_CODE); // R6
endmodule

// File: tb/rxq_ring_ctrl_tb.sv
module rxq_ring_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc = 1'b0, clr = 1'b0, wm = 1'b0;
   logic [5:0] cfg = 6'd0;
   logic [3:0] rd_ptr;
   logic [7:0] full;
   logic       empty, wm_irq, ovf;
   logic [4:0] code;

   int total = 0, bad = 0;
   logic finished = 1'b0;

   int       m_wr, m_rd, m_cnt;
   logic [7:0] m_full;
   logic [5:0] m_cfg;
   logic [4:0] m_code;
   logic       m_wm, m_ovf;

   always #2 clk = ~clk;

   rxq_ring_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .msg_accept_i(acc), .prog_is_tx_i(cfg),
      .rd_clear_i(clr), .wm_sel_i(wm), .rd_ptr_o(rd_ptr), .full_o(full),
      .empty_o(empty), .irq_code_o(code), .wm_irq_o(wm_irq), .overflow_o(ovf));

   function automatic int depth_of(logic [5:0] c);
      int d = 8;
      for (int k = 5; k >= 0; k--) if (c[k]) d = 2 + k;
      return d;
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset(input logic [5:0] c);
      m_cfg = c; m_full = '0; m_wr = 0; m_rd = 0; m_cnt = 0;
      m_code = 5'd0; m_wm = 1'b0; m_ovf = 1'b0;
   endtask

   task automatic model_step(input logic a, input logic r, input logic [5:0] c, input logic w);
      int d, nc;
      logic wok, cok;
      if (c != m_cfg) begin
         model_reset(c);                        // R9
      end else begin
         d   = depth_of(m_cfg);
         wok = a && !m_full[m_wr];
         cok = r && m_full[m_rd];
         if (a && !wok) m_ovf = 1'b1;
         nc  = m_cnt + int'(wok) - int'(cok);
         m_code = wok ? 5'b10000 : 5'b00000;
         m_wm   = wok && ((d - nc) == (w ? 4 : 1));
         if (wok) begin m_full[m_wr] = 1'b1; m_wr = (m_wr == d - 1) ? 0 : m_wr + 1; end
         if (cok) begin m_full[m_rd] = 1'b0; m_rd = (m_rd == d - 1) ? 0 : m_rd + 1; end
         m_cnt = nc;
      end
   endtask

   task automatic compare_all();
      chk(rd_ptr == 4'(m_rd), "R3 rd_ptr", int'(rd_ptr), m_rd);
      chk(full == m_full, "R2 full", int'(full), int'(m_full));
      chk(empty == !m_full[m_rd], "R4 empty", int'(empty), int'(!m_full[m_rd]));
      chk(code == m_code, "R5 code", int'(code), int'(m_code));
      chk(wm_irq == m_wm, "R6 wm", int'(wm_irq), int'(m_wm));
      chk(ovf == m_ovf, "R7 overflow", int'(ovf), int'(m_ovf));
   endtask

   task automatic cyc(input logic a, input logic r, input logic [5:0] c, input logic w);
      @(negedge clk);
      acc = a; clr = r; cfg = c; wm = w;
      model_step(a, r, c, w);
      @(posedge clk);
      #1;
      compare_all();
   endtask

   task automatic fill_check(input logic [5:0] c);
      int d = depth_of(c);
      cyc(1'b0, 1'b0, c, 1'b0);
      for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, c, 1'b0);
      chk(full == 8'((1 << d) - 1), "R1 depth mask", int'(full), (1 << d) - 1);
      chk(ovf == 1'b1, "R7 drop when full", int'(ovf), 1);
      for (int i = 0; i < d; i++) cyc(1'b0, 1'b1, c, 1'b1);
      chk(empty == 1'b1, "R3 drained", int'(empty), 1);
      begin
         logic [3:0] keep = rd_ptr;
         cyc(1'b0, 1'b1, c, 1'b0);
         chk(rd_ptr == keep && full == 8'd0, "R8 clear on empty", int'(rd_ptr), int'(keep));
      end
   endtask

   initial begin
      model_reset(6'd0);
      repeat (3) @(posedge clk);
      #1;
      chk(rd_ptr == 0 && full == 0 && code == 0 && !wm_irq && !ovf && empty, "R10 reset",
          int'({rd_ptr, full}), 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      compare_all();

      fill_check(6'b000000);   // depth 8
      fill_check(6'b001000);   // depth 5
      fill_check(6'b000001);   // depth 2
      fill_check(6'b100000);   // depth 7

      // config change with pending traffic and an accept in the same cycle
      cyc(1'b1, 1'b0, 6'b100000, 1'b0);
      cyc(1'b1, 1'b0, 6'b100000, 1'b0);
      cyc(1'b1, 1'b1, 6'b000100, 1'b0);
      chk(full == 0 && rd_ptr == 0 && code == 0, "R9 config flush", int'(full), 0);

      // watermark both levels with simultaneous accept and release
      for (int lvl = 0; lvl < 2; lvl++) begin
         for (int i = 0; i < 9; i++) cyc(1'b1, (i % 3) == 2, 6'b000000, lvl[0]);
         for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, 6'b000000, lvl[0]);
      end

      process::self().srandom(32'h5EED_0042);
      for (int ph = 0; ph < 12; ph++) begin
         logic [5:0] pc;
         int pa, pr;
         pc = ($urandom % 3 == 0) ? 6'd0 : 6'(1 << ($urandom % 6));
         pa = 30 + ($urandom % 60);
         pr = 30 + ($urandom % 60);
         for (int i = 0; i < 300; i++) begin
            logic [5:0] cc = ($urandom % 150 == 0) ? 6'($urandom) : pc;
            cyc(($urandom % 100) < pa, ($urandom % 100) < pr, cc, $urandom % 2 == 1);
            pc = cc;
         end
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule